// File: doc/BRIEF.md
# Threshold Peak Rate Meter

This block watches a stream of signed samples and measures how often the signal rises above a programmable level. Each sample that arrives with its valid strobe is compared against a threshold. Samples that lie strictly above it are peaks. Each peak raises a single-cycle event output, so a host is notified only when a peak occurs and not for ordinary samples. Peaks are also counted inside fixed windows.

A free-running period timer sets the window length. On every timer tick, the running count is moved into a result register and a result strobe pulses for one cycle. The counter then starts again for the next window. The count saturates instead of wrapping, and a sticky overflow flag travels with the captured result. Writing a new period restarts the timer and throws away the window that was in progress. The first result after reset covers a shortened window, and it is marked as partial.

Top module: `peak_rate_meter`

## Requirements
- R1: Samples and threshold are 16-bit two's complement and are compared as signed numbers. A valid sample is a peak only if its value is strictly greater than the threshold. A sample equal to the threshold is not a peak.
- R2: `peak_evt` is high for exactly one cycle, in the cycle after a valid peak sample. It stays low after a non-peak sample and after any cycle with `smp_valid` low.
- R3: The timer ticks once every N cycles, where N is the programmed period and a programmed value of 0 behaves as 1. After reset, N is `DEF_PERIOD`. The first tick falls in the N-th cycle after reset is released.
- R4: A tick loads `res_count` with the number of peaks counted since the previous window start. `res_valid` pulses for one cycle with it. Between ticks, `res_count`, `res_ovf` and `res_partial` hold their values.
- R5: A peak sample that arrives in the tick cycle is left out of the captured value and counts as 1 in the new window.
- R6: The window counter stops at its all-ones maximum (255 with the default `COUNT_W` of 8). Any peak beyond that sets an overflow flag that is reported on `res_ovf` with the capture. Both the count and the flag restart on the next window.
- R7: A cycle with `period_wr` high loads the new period, restarts the timer and clears the window count, including any peak in that same cycle. No capture happens in that cycle. The next capture comes N cycles after the write.
- R8: The first capture after reset has `res_partial` = 1 and covers N-1 sample cycles. Every later capture has `res_partial` = 0.
- R9: While reset is held, `peak_evt`, `res_valid`, `res_count`, `res_ovf` and `res_partial` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed sample value |
| thresh | input | SAMPLE_W | Signed peak threshold |
| period_wr | input | 1 | Load a new window period |
| period_val | input | PERIOD_W | Window length in cycles (0 acts as 1) |
| peak_evt | output | 1 | One-cycle pulse per peak |
| res_valid | output | 1 | One-cycle pulse on each capture |
| res_count | output | COUNT_W | Peaks in the last completed window |
| res_ovf | output | 1 | Counter saturated during that window |
| res_partial | output | 1 | Captured window was the shortened first one |

## Verification
The bench probes the comparison around the threshold with negative values, equal values and the two extreme codes. A design that compares unsigned or uses greater-or-equal would report peaks at the wrong samples. It places a peak exactly in the tick cycle and another in the period-write cycle. A design that sends the first peak to the wrong window, or keeps the second one, would capture a count that is off by one. It drives more peaks into a window than the counter can hold, checks that the count is clamped with overflow set, and checks that the next window starts clean. It also programs a period of zero and counts cycles to the first capture after reset, where an off-by-one timer or a missing partial flag would show.

// File: rtl/peak_meter_pkg.sv
package peak_meter_pkg;

    localparam int unsigned PM_SAMPLE_W   = 16;
    localparam int unsigned PM_COUNT_W    = 8;
    localparam int unsigned PM_PERIOD_W   = 16;
    localparam int unsigned PM_DEF_PERIOD = 8;

    // Action taken by the window counter in one cycle
    typedef enum logic [2:0] {
        CNT_HOLD,
        CNT_INC,
        CNT_SATURATE,
        CNT_RESTART,
        CNT_DISCARD
    } cnt_action_e;

    function automatic cnt_action_e pick_action(
        input logic clear,
        input logic tick,
        input logic hit,
        input logic at_max
    );
        if (clear)       return CNT_DISCARD;
        else if (tick)   return CNT_RESTART;
        else if (!hit)   return CNT_HOLD;
        else if (at_max) return CNT_SATURATE;
        else             return CNT_INC;
    endfunction

endpackage

// File: rtl/pk_compare.sv
module pk_compare #(
    parameter int unsigned SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                valid_i,
    input  logic [SAMPLE_W-1:0] data_i,
    input  logic [SAMPLE_W-1:0] thresh_i,
    output logic                hit_o,
    output logic                peak_o
);

    logic signed [SAMPLE_W-1:0] s_data;
    logic signed [SAMPLE_W-1:0] s_thr;

    assign s_data = $signed(data_i);
    assign s_thr  = $signed(thresh_i);
    assign hit_o  = valid_i && (s_data > s_thr);

    always_ff @(posedge clk) begin
        if (rst) peak_o <= 1'b0;
        else     peak_o <= hit_o;
    end

    // R2
    peak_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        peak_o |-> $past(valid_i));

endmodule

// File: rtl/pk_period_timer.sv
module pk_period_timer #(
    parameter int unsigned PERIOD_W   = 16,
    parameter int unsigned DEF_PERIOD = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_i,
    input  logic [PERIOD_W-1:0] val_i,
    output logic                tick_o
);

    localparam logic [PERIOD_W-1:0] ONE      = PERIOD_W'(1);
    localparam logic [PERIOD_W-1:0] DEF_LOAD = (DEF_PERIOD == 0) ? ONE : PERIOD_W'(DEF_PERIOD);

    logic [PERIOD_W-1:0] period_q;
    logic [PERIOD_W-1:0] tmr_q;
    logic [PERIOD_W-1:0] eff_val;

    assign eff_val = (val_i == '0) ? ONE : val_i;
    assign tick_o  = !wr_i && (tmr_q == (period_q - ONE));

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= DEF_LOAD;
            tmr_q    <= '0;
        end else if (wr_i) begin
            period_q <= eff_val;
            tmr_q    <= '0;
        end else if (tick_o) begin
            tmr_q    <= '0;
        end else begin
            tmr_q    <= tmr_q + ONE;
        end
    end

    // R3
    tmr_range_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_q < period_q);

    // R7
    wr_restart_chk: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (tmr_q == '0));

endmodule

// File: rtl/pk_counter.sv
module pk_counter
    import peak_meter_pkg::*;
#(
    parameter int unsigned COUNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hit_i,
    input  logic               tick_i,
    input  logic               clr_i,
    output logic               res_valid_o,
    output logic [COUNT_W-1:0] res_count_o,
    output logic               res_ovf_o,
    output logic               res_partial_o
);

    localparam logic [COUNT_W-1:0] CNT_MAX = '1;

    logic [COUNT_W-1:0] cnt_q;
    logic               ovf_q;
    logic               first_q;
    cnt_action_e        act;

    assign act = pick_action(clr_i, tick_i, hit_i, cnt_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q         <= '0;
            ovf_q         <= 1'b0;
            first_q       <= 1'b1;
            res_valid_o   <= 1'b0;
            res_count_o   <= '0;
            res_ovf_o     <= 1'b0;
            res_partial_o <= 1'b0;
        end else begin
            res_valid_o <= 1'b0;
            unique case (act)
                CNT_DISCARD: begin
                    cnt_q <= '0;
                    ovf_q <= 1'b0;
                end
                CNT_RESTART: begin
                    res_count_o   <= cnt_q;
                    res_ovf_o     <= ovf_q;
                    res_partial_o <= first_q;
                    res_valid_o   <= 1'b1;
                    first_q       <= 1'b0;
                    cnt_q         <= COUNT_W'(hit_i);
                    ovf_q         <= 1'b0;
                end
                CNT_SATURATE: ovf_q <= 1'b1;
                CNT_INC:      cnt_q <= cnt_q + COUNT_W'(1);
                default:      ;
            endcase
        end
    end

    // R4
    cap_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> $past(tick_i && !clr_i));

    // R6
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && hit_i && !tick_i && !clr_i) |=> (cnt_q == CNT_MAX && ovf_q));

    // R6
    ovf_implies_max_chk: assert property (@(posedge clk) disable iff (rst)
        res_ovf_o |-> (res_count_o == CNT_MAX));

endmodule

// File: rtl/peak_rate_meter.sv
module peak_rate_meter
    import peak_meter_pkg::*;
#(
    parameter int unsigned SAMPLE_W   = PM_SAMPLE_W,
    parameter int unsigned COUNT_W    = PM_COUNT_W,
    parameter int unsigned PERIOD_W   = PM_PERIOD_W,
    parameter int unsigned DEF_PERIOD = PM_DEF_PERIOD
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [SAMPLE_W-1:0] thresh,
    input  logic                period_wr,
    input  logic [PERIOD_W-1:0] period_val,
    output logic                peak_evt,
    output logic                res_valid,
    output logic [COUNT_W-1:0]  res_count,
    output logic                res_ovf,
    output logic                res_partial
);

    logic hit;
    logic tick;

    pk_compare #(.SAMPLE_W(SAMPLE_W)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .valid_i  (smp_valid),
        .data_i   (smp_data),
        .thresh_i (thresh),
        .hit_o    (hit),
        .peak_o   (peak_evt)
    );

    pk_period_timer #(.PERIOD_W(PERIOD_W), .DEF_PERIOD(DEF_PERIOD)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (period_wr),
        .val_i  (period_val),
        .tick_o (tick)
    );

    pk_counter #(.COUNT_W(COUNT_W)) u_cnt (
        .clk           (clk),
        .rst           (rst),
        .hit_i         (hit),
        .tick_i        (tick),
        .clr_i         (period_wr),
        .res_valid_o   (res_valid),
        .res_count_o   (res_count),
        .res_ovf_o     (res_ovf),
        .res_partial_o (res_partial)
    );

    // R7
    no_capture_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        period_wr |=> !res_valid);

endmodule

// File: tb/sim_peak_rate_meter.sv
module sim_peak_rate_meter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic [15:0] thresh = '0;
    logic        period_wr = 1'b0;
    logic [15:0] period_val = '0;
    logic        peak_evt, res_valid, res_ovf, res_partial;
    logic [7:0]  res_count;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    peak_rate_meter u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .thresh(thresh), .period_wr(period_wr), .period_val(period_val),
        .peak_evt(peak_evt), .res_valid(res_valid), .res_count(res_count),
        .res_ovf(res_ovf), .res_partial(res_partial)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [15:0] d;
        logic [15:0] t;
        logic        e;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{16'd100,   16'd50,    1'b1},
        '{16'd50,    16'd50,    1'b0},
        '{16'd51,    16'd50,    1'b1},
        '{16'hFFFF,  16'hFFFE,  1'b1},
        '{16'hFFFE,  16'hFFFF,  1'b0},
        '{16'd0,     16'hFFFF,  1'b1},
        '{16'h8000,  16'd0,     1'b0},
        '{16'h7FFF,  16'h8000,  1'b1},
        '{16'h8000,  16'h8000,  1'b0},
        '{16'd5,     16'd200,   1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one cycle from a falling edge, return at the next falling edge
    task automatic cyc(input logic v, input logic [15:0] d,
                       input logic w = 1'b0, input logic [15:0] p = '0);
        smp_valid  = v;
        smp_data   = d;
        period_wr  = w;
        period_val = p;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        @(negedge clk);
        cyc(1'b1, 16'd1);
        cyc(1'b1, 16'd1);
        // R9 reset state
        check("R9 peak_evt", peak_evt, 0);
        check("R9 res_valid", res_valid, 0);
        check("R9 res_count", res_count, 0);
        check("R9 res_ovf", res_ovf, 0);
        check("R9 res_partial", res_partial, 0);

        // R8/R3: first window, default period 8, peaks in cycles 1..7
        rst = 1'b0;
        thresh = 16'd0;
        for (int i = 0; i < 7; i++) begin
            cyc(1'b1, 16'd1);
            check("R3 no early capture", res_valid, 0);
        end
        cyc(1'b1, 16'd1);   // tick cycle, peak goes to next window (R5)
        check("R3 first tick", res_valid, 1);
        check("R8 first count", res_count, 7);
        check("R8 partial flag", res_partial, 1);
        check("R2 peak event", peak_evt, 1);
        cyc(1'b0, 16'd0);
        check("R4 one-cycle valid", res_valid, 0);
        check("R4 result held", res_count, 7);
        check("R2 no event on invalid", peak_evt, 0);
        for (int i = 0; i < 6; i++) cyc(1'b0, 16'd0);
        cyc(1'b0, 16'd0);
        check("R4 second capture", res_valid, 1);
        check("R5 tick-cycle peak counted next", res_count, 1);
        check("R8 later not partial", res_partial, 0);

        // R1/R2 vector walk
        for (int i = 0; i < 10; i++) begin
            thresh = VEC[i].t;
            cyc(1'b1, VEC[i].d);
            check("R1 signed strict compare", peak_evt, VEC[i].e);
        end
        thresh = 16'd0;
        cyc(1'b0, 16'd1000);
        check("R2 invalid sample ignored", peak_evt, 0);

        // R7: period write with a discarded peak, period 4
        cyc(1'b1, 16'd1, 1'b1, 16'd4);
        check("R7 no capture on write", res_valid, 0);
        cyc(1'b1, 16'd1);
        cyc(1'b0, 16'd0);
        cyc(1'b1, 16'd1);
        check("R7 no capture before N", res_valid, 0);
        cyc(1'b0, 16'd0);
        check("R7 capture N after write", res_valid, 1);
        check("R7 write-cycle peak discarded", res_count, 2);
        for (int i = 0; i < 3; i++) cyc(1'b0, 16'd0);
        check("R3 period 4 gap", res_valid, 0);
        cyc(1'b0, 16'd0);
        check("R3 period 4 tick", res_valid, 1);
        check("R4 empty window", res_count, 0);

        // R3: period 0 acts as 1
        cyc(1'b0, 16'd0, 1'b1, 16'd0);
        check("R3 zero period write", res_valid, 0);
        cyc(1'b1, 16'd1);
        check("R3 zero period tick", res_valid, 1);
        check("R3 zero period count", res_count, 0);
        cyc(1'b0, 16'd0);
        check("R3 zero period every cycle", res_valid, 1);
        check("R5 zero period count", res_count, 1);
        cyc(1'b0, 16'd0);
        check("R3 zero period empty", res_count, 0);

        // R6 saturation, period 300
        cyc(1'b0, 16'd0, 1'b1, 16'd300);
        for (int i = 0; i < 299; i++) cyc(1'b1, 16'd1);
        check("R6 no capture yet", res_valid, 0);
        cyc(1'b1, 16'd1);
        check("R6 capture", res_valid, 1);
        check("R6 saturated count", res_count, 255);
        check("R6 overflow flag", res_ovf, 1);
        for (int i = 0; i < 299; i++) cyc(1'b0, 16'd0);
        check("R4 ovf held", res_ovf, 1);
        cyc(1'b0, 16'd0);
        check("R6 next capture", res_valid, 1);
        check("R6 restart count", res_count, 1);
        check("R6 overflow cleared", res_ovf, 0);

        finish_run();
    end

endmodule